// File: doc/BRIEF.md
# Embedded Video Sync Code Capture

This block sits on an 8-bit digitized video byte stream. The stream has no separate sync wires. Frame and line timing travel inside the data as short codes. The block finds each code, follows the frame flag and the active-line state, and decides for every byte in the same cycle whether it goes to an external asynchronous SRAM buffer. A buffer write carries either the status byte of a code or an active pixel byte.

Buffer addresses come from an internal counter. The counter advances once per stored byte and returns to zero when a new frame starts while capture is enabled. Writes arrive at an irregular rate. A write can follow the previous one in the next cycle, or only after several idle cycles. The block also gives one-cycle frame and line pulses and a sticky overflow flag, which rises when a frame's data no longer fits in the buffer.

Top module: `vsync_capture`

## Requirements
- R1: While rst_ni is low and after its release, sram_we_no is 1 and sram_addr_o, sram_data_o, frame_pulse_o, line_pulse_o and overflow_o are all 0.
- R2: A code is the valid-byte sequence 0xFF, 0x00, 0x00 followed by a status byte. Cycles with pix_valid_i low do not break the sequence. Any other valid byte restarts the search. A 0xFF also starts a new candidate sequence.
- R3: In the status byte, bit 6 is the frame flag, bit 5 marks blanking and bit 4 marks end of line. A code with bits 5 and 4 both 0 opens the active region. Any other code closes it.
- R4: When capture is enabled, the status byte of every code is stored. A pixel byte is stored only inside the active region and only if its value is neither 0x00 nor 0xFF. Bytes outside the active region are never stored.
- R5: A byte sampled on a clock edge shows up on the SRAM pins after that edge. sram_we_no is low for exactly that one cycle, and bytes that are stored back to back give consecutive write cycles.
- R6: The address rises by one for each stored byte. sram_addr_o and sram_data_o hold their values in cycles without a write.
- R7: frame_pulse_o is high for one cycle, aligned with the code's write slot, when a code's frame flag differs from the previous code's flag. The stored flag starts at 0 after reset. If capture is enabled, that code's status byte is written at address 0 and the count continues from 1.
- R8: line_pulse_o is high for one cycle, aligned with the code's write slot, for each code that opens the active region.
- R9: While cap_en_i is low, no write happens and the address count does not move. Code detection, the region state and both pulses keep working.
- R10: Once all 2**ADDR_W addresses have been written since the last frame start, the next store request is dropped and overflow_o goes high. overflow_o then stays high, and no further writes happen until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Video byte |
| pix_valid_i | input | 1 | pix_i carries a byte this cycle |
| cap_en_i | input | 1 | Capture enable for buffer writes |
| sram_addr_o | output | ADDR_W | SRAM address |
| sram_data_o | output | 8 | SRAM write data |
| sram_we_no | output | 1 | SRAM write strobe, active low |
| frame_pulse_o | output | 1 | New-frame pulse |
| line_pulse_o | output | 1 | Active-line start pulse |
| overflow_o | output | 1 | Sticky buffer overflow flag |

## Verification
The assertions check on every cycle that a write only follows a sampled byte while capture is enabled. They also check that addresses step by one except on a return to zero, that a frame pulse combined with a write lands at address 0, that pins hold between writes, and that overflow is sticky and blocks writes. Whether the right bytes are picked needs the bench's scenarios. Those scenarios cover preambles split by idle cycles, broken preambles, reserved pixel values, blanking, capture switched off and a frame too long for the buffer. The bench compares every cycle against a model built from the requirements.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned FRAME_BIT = 6;
  localparam int unsigned BLANK_BIT = 5;
  localparam int unsigned EOL_BIT   = 4;
  localparam logic [BYTE_W-1:0] PRE_HI = 8'hFF;
  localparam logic [BYTE_W-1:0] PRE_LO = 8'h00;

  typedef enum logic [1:0] {DS_IDLE, DS_HI, DS_LO1, DS_LO2} det_state_e;

  typedef struct packed {
    logic frame;
    logic blank;
    logic eol;
  } status_t;
endpackage

// File: rtl/vcap_code_det.sv
module vcap_code_det
  import vcap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  output logic              hit_o,
  output status_t           status_o
);
  det_state_e state_q, state_d;

  assign hit_o    = valid_i && (state_q == DS_LO2);
  assign status_o = '{frame: byte_i[FRAME_BIT], blank: byte_i[BLANK_BIT], eol: byte_i[EOL_BIT]};

  always_comb begin
    state_d = state_q;
    if (valid_i) begin
      if (state_q == DS_LO2)                         state_d = DS_IDLE;
      else if (byte_i == PRE_HI)                     state_d = DS_HI;
      else if (byte_i == PRE_LO && state_q == DS_HI)  state_d = DS_LO1;
      else if (byte_i == PRE_LO && state_q == DS_LO1) state_d = DS_LO2;
      else                                           state_d = DS_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DS_IDLE;
    else         state_q <= state_d;
  end

  // a status byte always ends the preamble
  AST_CODE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o); // R2
endmodule

// File: rtl/vcap_select.sv
module vcap_select
  import vcap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              hit_i,
  input  status_t           status_i,
  output logic              store_o,
  output logic              frame_tgl_o,
  output logic              line_start_o
);
  logic frame_q, active_q;
  logic pix_ok;

  assign pix_ok       = (byte_i != PRE_HI) && (byte_i != PRE_LO);
  assign frame_tgl_o  = hit_i && (status_i.frame != frame_q);
  assign line_start_o = hit_i && !status_i.blank && !status_i.eol;
  assign store_o      = valid_i && (hit_i || (active_q && pix_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q  <= 1'b0;
      active_q <= 1'b0;
    end else if (hit_i) begin
      frame_q  <= status_i.frame;
      active_q <= line_start_o;
    end
  end

  AST_ACTIVE_FROM_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(hit_i)); // R3
endmodule

// File: rtl/vcap_addr.sv
module vcap_addr #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  logic              en_i,
  input  logic              restart_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ovf_o
);
  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1) << ADDR_W;

  logic [PTR_W-1:0] ptr_q;
  logic             ovf_q, set_ovf;

  always_comb begin
    wr_o    = 1'b0;
    addr_o  = ptr_q[ADDR_W-1:0];
    set_ovf = 1'b0;
    if (en_i && store_i && !ovf_q) begin
      if (restart_i) begin
        wr_o   = 1'b1;
        addr_o = '0;
      end else if (ptr_q < DEPTH) begin
        wr_o = 1'b1;
      end else begin
        set_ovf = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_o)    ptr_q <= {1'b0, addr_o} + PTR_W'(1);
      if (set_ovf) ovf_q <= 1'b1;
    end
  end

  assign ovf_o = ovf_q;

  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= DEPTH); // R10
  AST_PTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ptr_q)); // R9
endmodule

// File: rtl/vcap_wr_port.sv
module vcap_wr_port
  import vcap_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              frame_i,
  input  logic              line_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              we_no,
  output logic              frame_o,
  output logic              line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      data_o  <= '0;
      we_no   <= 1'b1;
      frame_o <= 1'b0;
      line_o  <= 1'b0;
    end else begin
      we_no   <= !wr_i;
      frame_o <= frame_i;
      line_o  <= line_i;
      if (wr_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_no |-> ($stable(addr_o) && $stable(data_o))); // R6
endmodule

// File: rtl/vsync_capture.sv
module vsync_capture
  import vcap_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        pix_i,
  input  logic              pix_valid_i,
  input  logic              cap_en_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [7:0]        sram_data_o,
  output logic              sram_we_no,
  output logic              frame_pulse_o,
  output logic              line_pulse_o,
  output logic              overflow_o
);
  logic              hit, store, frame_tgl, line_start, wr;
  logic [ADDR_W-1:0] wr_addr;
  status_t           status;

  vcap_code_det i_det (
    .clk_i, .rst_ni, .byte_i(pix_i), .valid_i(pix_valid_i),
    .hit_o(hit), .status_o(status)
  );

  vcap_select i_sel (
    .clk_i, .rst_ni, .byte_i(pix_i), .valid_i(pix_valid_i),
    .hit_i(hit), .status_i(status), .store_o(store),
    .frame_tgl_o(frame_tgl), .line_start_o(line_start)
  );

  vcap_addr #(.ADDR_W(ADDR_W)) i_addr (
    .clk_i, .rst_ni, .store_i(store), .en_i(cap_en_i), .restart_i(frame_tgl),
    .wr_o(wr), .addr_o(wr_addr), .ovf_o(overflow_o)
  );

  vcap_wr_port #(.ADDR_W(ADDR_W)) i_port (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i(wr_addr), .data_i(pix_i),
    .frame_i(frame_tgl), .line_i(line_start),
    .addr_o(sram_addr_o), .data_o(sram_data_o), .we_no(sram_we_no),
    .frame_o(frame_pulse_o), .line_o(line_pulse_o)
  );

  AST_WRITE_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> $past(pix_valid_i && cap_en_i)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && sram_addr_o != '0) |-> sram_addr_o == ADDR_W'($past(sram_addr_o) + 1'b1)); // R6
  AST_FRAME_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_pulse_o && !sram_we_no) |-> sram_addr_o == '0); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> (overflow_o && sram_we_no)); // R10
endmodule

// File: tb/test_vsync_capture.sv
module test_vsync_capture;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    pix = '0;
  logic          pix_valid = 1'b0;
  logic          cap_en = 1'b0;
  logic [AW-1:0] sram_addr;
  logic [7:0]    sram_data;
  logic          sram_we_n, frame_pulse, line_pulse, overflow;

  vsync_capture #(.ADDR_W(AW)) i_vsync_capture (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .pix_valid_i(pix_valid),
    .cap_en_i(cap_en), .sram_addr_o(sram_addr), .sram_data_o(sram_data),
    .sram_we_no(sram_we_n), .frame_pulse_o(frame_pulse),
    .line_pulse_o(line_pulse), .overflow_o(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, writes_seen = 0;
  bit done = 0;

  // reference state
  int m_st = 0, m_ptr = 0;
  bit m_f = 0, m_act = 0, m_ovf = 0;
  bit exp_we = 1, exp_fp = 0, exp_lp = 0, exp_ovf = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [7:0]    exp_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(sram_we_n == exp_we, "R5 write strobe", sram_we_n, exp_we);
    if (!exp_we && !sram_we_n) begin
      chk(sram_addr == exp_addr, "R6 address", sram_addr, exp_addr);
      chk(sram_data == exp_data, "R4 data", sram_data, exp_data);
    end
    if (!sram_we_n) writes_seen++;
    chk(frame_pulse == exp_fp, "R7 frame pulse", frame_pulse, exp_fp);
    chk(line_pulse == exp_lp, "R8 line pulse", line_pulse, exp_lp);
    chk(overflow == exp_ovf, "R10 overflow", overflow, exp_ovf);
  endtask

  task automatic model(input bit v, input logic [7:0] b, input bit en);
    bit hit = 0, store = 0, tgl = 0;
    exp_we = 1; exp_fp = 0; exp_lp = 0;
    if (v) begin
      if (m_st == 3) begin hit = 1; m_st = 0; end
      else if (b == 8'hFF) m_st = 1;
      else if (b == 8'h00 && m_st == 1) m_st = 2;
      else if (b == 8'h00 && m_st == 2) m_st = 3;
      else m_st = 0;
      if (hit) begin
        tgl = (b[6] != m_f);
        m_f = b[6];
        exp_fp = tgl;
        exp_lp = !b[5] && !b[4];
        store = 1;
        m_act = !b[5] && !b[4];
      end else begin
        store = m_act && b != 8'h00 && b != 8'hFF;
      end
    end
    if (v && en && store && !m_ovf) begin
      if (tgl) begin
        exp_we = 0; exp_addr = '0; exp_data = b; m_ptr = 1;
      end else if (m_ptr < DEPTH) begin
        exp_we = 0; exp_addr = AW'(m_ptr); exp_data = b; m_ptr++;
      end else begin
        m_ovf = 1;
      end
    end
    exp_ovf = m_ovf;
  endtask

  task automatic step(input bit v, input logic [7:0] b, input bit en);
    @(negedge clk);
    compare();
    model(v, b, en);
    pix_valid = v; pix = b; cap_en = en;
  endtask

  task automatic idle(input int n, input bit en);
    for (int i = 0; i < n; i++) step(1'b0, 8'($urandom), en);
  endtask

  task automatic send_code(input bit f, input bit bl, input bit eol, input bit en, input bit gaps);
    logic [7:0] s;
    s = {1'b1, f, bl, eol, 4'($urandom)};
    step(1'b1, 8'hFF, en); if (gaps) idle(1, en);
    step(1'b1, 8'h00, en); if (gaps) idle(2, en);
    step(1'b1, 8'h00, en); if (gaps) idle(1, en);
    step(1'b1, s, en);
  endtask

  task automatic send_pixels(input int n, input bit en, input int gap_pct);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(99) < gap_pct) idle($urandom_range(3, 1), en);
      step(1'b1, 8'($urandom_range(254, 1)), en);
    end
  endtask

  int w0;
  int seed_init;

  initial begin
    seed_init = $urandom(32'd2718);
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(sram_we_n == 1'b1, "R1 we_n in reset", sram_we_n, 1);
    chk(sram_addr == '0 && sram_data == '0, "R1 addr/data in reset", sram_addr, 0);
    chk(!frame_pulse && !line_pulse && !overflow, "R1 flags in reset", overflow, 0);
    rst_n = 1'b1;
    idle(2, 1'b0);

    // R9: capture off, pulses still run, no writes
    w0 = writes_seen;
    send_code(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send_pixels(6, 1'b0, 0);
    idle(2, 1'b0);
    chk(writes_seen == w0, "R9 no writes while disabled", writes_seen, w0);

    // R7/R3: frame toggle with capture on, status at address 0, then pixels
    send_code(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 8'h00, 1'b1);   // R4 reserved value skipped
    step(1'b1, 8'h42, 1'b1);
    step(1'b1, 8'hFF, 1'b1);   // R4 reserved value skipped, starts candidate
    step(1'b1, 8'h17, 1'b1);   // R2 broken preamble, stored as pixel
    idle(3, 1'b1);
    step(1'b1, 8'h81, 1'b1);
    // R2: preamble split by idle cycles, end-of-line code closes region
    send_code(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    w0 = writes_seen;
    send_pixels(5, 1'b1, 30);  // R3/R4 outside active region
    idle(2, 1'b1);
    chk(writes_seen == w0 + 1, "R3 only code stored after end of line", writes_seen, w0 + 1);
    // blanking code then line start
    send_code(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    send_pixels(3, 1'b1, 0);
    send_code(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send_pixels(4, 1'b1, 0);   // R5 back-to-back writes

    // random frames and lines
    for (int fr = 0; fr < 20; fr++) begin
      bit en = ($urandom_range(9) != 0);
      send_code(fr[0], 1'b1, 1'b1, en, $urandom_range(1));
      for (int ln = 0; ln < 4; ln++) begin
        send_code(fr[0], 1'b0, 1'b0, en, $urandom_range(1));
        send_pixels($urandom_range(8, 2), en, 25);
        send_code(fr[0], 1'b0, 1'b1, en, 1'b0);
        send_pixels($urandom_range(3), en, 0);
      end
    end
    idle(2, 1'b1);

    // R10: frame too long for the buffer
    send_code(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    send_code(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send_pixels(DEPTH + 10, 1'b1, 10);
    idle(2, 1'b1);
    chk(overflow == 1'b1, "R10 overflow raised", overflow, 1);
    w0 = writes_seen;
    send_code(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    send_pixels(5, 1'b1, 0);
    idle(2, 1'b1);
    chk(writes_seen == w0, "R10 no writes after overflow", writes_seen, w0);
    chk(overflow == 1'b1, "R10 overflow sticky", overflow, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule